// File: doc/BRIEF.md
# Looping Sample Address Generator

This block produces the memory address of the next sample for one wavetable playback voice. Software programs a loop base address, an end offset (the distance in frames from the loop start to the loop end) and a pitch step. It then launches the voice by writing a one to the voice's bit in a start command. On every sample tick a running voice adds the step to a 16.12 fixed-point phase. When the integer phase passes the end offset, the phase folds back to the loop start, keeps its fractional remainder, and raises an end-of-loop interrupt.

The address sent out is the loop base plus the integer phase, scaled by the bytes in one sample frame. A frame is 1, 2 or 4 bytes, depending on sample width (8 or 16 bit) and channel count (mono or stereo). A half flag shows whether the phase sits in the upper half of the loop. Software uses it to refill the two halves of a circular buffer alternately.

The run bits form a bank sized by the voice-count parameter. Start, stop and interrupt-clear commands share one write mask. The address engine follows the run bit chosen by a parameter.

Top module: `wave_addr_gen`

## Requirements
- R1: After reset, all run bits, the address, the half flag and the interrupt are 0. The base, end offset and step registers are also 0.
- R2: A start write sets run bit n only where mask bit n is 1. Zero mask bits leave their run bits unchanged. Launching an idle engine voice resets its phase to 0. A start write to a voice that is already running leaves its phase unchanged.
- R3: A stop write clears run bit n where mask bit n is 1. Zero mask bits have no effect. If start and stop hit the same bit in one cycle, the voice ends up stopped.
- R4: Each tick adds the step (4.12 format) to the 16.12 phase while the engine voice runs. Ticks have no effect on a stopped voice.
- R5: If a tick makes the integer phase exceed the end offset, the phase is reduced by (end offset + 1) in its integer part, keeping the fraction. The end-of-loop interrupt is then set in the next cycle.
- R6: A clear write with a 1 in the engine voice's mask bit clears the interrupt. A 0 in that bit leaves the interrupt set. A wrap in the same cycle as a clear leaves the interrupt set.
- R7: The half flag is 1 exactly when the integer phase is greater than the end offset shifted right by one.
- R8: The address is base + (integer phase << s). Here s = width16 + stereo, giving 1, 2 or 4 bytes per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_we_i | input | 1 | Start command strobe |
| stop_we_i | input | 1 | Stop command strobe |
| irq_clr_we_i | input | 1 | Interrupt clear strobe |
| cmd_mask_i | input | NUM_VOICES | Per-voice mask for start, stop and clear |
| base_we_i | input | 1 | Loop base write strobe |
| base_i | input | ADDR_W | Loop base byte address |
| eso_we_i | input | 1 | End offset write strobe |
| eso_i | input | INT_W | End offset in frames |
| step_we_i | input | 1 | Step write strobe |
| step_i | input | STEP_W | Pitch step, 4.12 fixed point |
| width16_i | input | 1 | 1 selects 16-bit samples |
| stereo_i | input | 1 | 1 selects stereo frames |
| tick_i | input | 1 | Sample tick |
| run_o | output | NUM_VOICES | Run bits |
| addr_o | output | ADDR_W | Current sample byte address |
| half_o | output | 1 | Phase is in the upper half of the loop |
| eol_irq_o | output | 1 | End-of-loop interrupt |

## Verification
A wrapping tick and an interrupt-clear write can fall in the same cycle. The bench brings the phase to one step short of the end offset. It then drives the tick and the clear in the same cycle, and expects the interrupt to stay set and the address to show the folded position. A start and a stop aimed at the same voice bit also collide. The bench drives both in one cycle and expects the run bit to read 0, with later ticks leaving the address unchanged.

// File: rtl/wag_pkg.sv
package wag_pkg;
  typedef enum logic [1:0] {
    FRAME_1B = 2'd0,
    FRAME_2B = 2'd1,
    FRAME_4B = 2'd2
  } frame_e;

  function automatic frame_e frame_sel(input logic w16, input logic st);
    case ({w16, st})
      2'b00:   return FRAME_1B;
      2'b11:   return FRAME_4B;
      default: return FRAME_2B;
    endcase
  endfunction
endpackage

// File: rtl/wag_run_bank.sv
module wag_run_bank #(
  parameter int NUM_VOICES = 4,
  parameter int VOICE_SEL  = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_we_i,
  input  logic                  stop_we_i,
  input  logic [NUM_VOICES-1:0] mask_i,
  output logic [NUM_VOICES-1:0] run_o,
  output logic                  launch_o
);
  logic [NUM_VOICES-1:0] run_q;

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     run_q[v] <= 1'b0;
      else if (stop_we_i && mask_i[v])  run_q[v] <= 1'b0;  // stop dominates
      else if (start_we_i && mask_i[v]) run_q[v] <= 1'b1;
    end
  end

  // 0->1 transition of the engine voice
  assign launch_o = start_we_i && mask_i[VOICE_SEL] && !run_q[VOICE_SEL]
                    && !(stop_we_i && mask_i[VOICE_SEL]);
  assign run_o = run_q;
endmodule

// File: rtl/wag_phase_acc.sv
module wag_phase_acc #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 12,
  parameter int STEP_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    launch_i,
  input  logic                    run_i,
  input  logic                    tick_i,
  input  logic [STEP_W-1:0]       step_i,
  input  logic [INT_W-1:0]        eso_i,
  output logic [INT_W+FRAC_W-1:0] phase_o,
  output logic                    wrap_o
);
  localparam int PW = INT_W + FRAC_W;
  localparam int XW = PW + 1;

  logic [PW-1:0]    phase_q;
  logic [XW-1:0]    sum;
  logic [INT_W:0]   sum_int;
  logic [XW-1:0]    fold_amt;
  logic [XW-1:0]    folded;
  logic             past_end;
  logic             adv;

  assign sum      = {1'b0, phase_q} + XW'(step_i);
  assign sum_int  = sum[XW-1:FRAC_W];
  assign past_end = sum_int > {1'b0, eso_i};
  assign fold_amt = {({1'b0, eso_i} + (INT_W+1)'(1)), {FRAC_W{1'b0}}};
  assign folded   = sum - fold_amt;
  assign adv      = tick_i && run_i && !launch_i;
  assign wrap_o   = adv && past_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       phase_q <= '0;
    else if (launch_i) phase_q <= '0;
    else if (adv)      phase_q <= past_end ? folded[PW-1:0] : sum[PW-1:0];
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/wag_addr_map.sv
module wag_addr_map
  import wag_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int INT_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [INT_W-1:0]  pos_i,
  input  logic [INT_W-1:0]  eso_i,
  input  logic              width16_i,
  input  logic              stereo_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              half_o
);
  frame_e              fsel;
  logic [ADDR_W-1:0]   pos_x;
  logic [ADDR_W-1:0]   ofs;

  assign fsel  = frame_sel(width16_i, stereo_i);
  assign pos_x = ADDR_W'(pos_i);

  always_comb begin
    unique case (fsel)
      FRAME_1B: ofs = pos_x;
      FRAME_2B: ofs = pos_x << 1;
      FRAME_4B: ofs = pos_x << 2;
      default:  ofs = pos_x;
    endcase
  end

  assign addr_o = base_i + ofs;
  assign half_o = pos_i > (eso_i >> 1);
endmodule

// File: rtl/wave_addr_gen.sv
module wave_addr_gen #(
  parameter int NUM_VOICES = 4,
  parameter int VOICE_SEL  = 0,
  parameter int ADDR_W     = 24,
  parameter int INT_W      = 16,
  parameter int FRAC_W     = 12,
  parameter int STEP_W     = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_we_i,
  input  logic                  stop_we_i,
  input  logic                  irq_clr_we_i,
  input  logic [NUM_VOICES-1:0] cmd_mask_i,
  input  logic                  base_we_i,
  input  logic [ADDR_W-1:0]     base_i,
  input  logic                  eso_we_i,
  input  logic [INT_W-1:0]      eso_i,
  input  logic                  step_we_i,
  input  logic [STEP_W-1:0]     step_i,
  input  logic                  width16_i,
  input  logic                  stereo_i,
  input  logic                  tick_i,
  output logic [NUM_VOICES-1:0] run_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic                  half_o,
  output logic                  eol_irq_o
);
  localparam int PW = INT_W + FRAC_W;

  logic [ADDR_W-1:0] base_q;
  logic [INT_W-1:0]  eso_q;
  logic [STEP_W-1:0] step_q;
  logic [PW-1:0]     phase;
  logic              launch;
  logic              wrap_evt;
  logic              irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      eso_q  <= '0;
      step_q <= '0;
    end else begin
      if (base_we_i) base_q <= base_i;
      if (eso_we_i)  eso_q  <= eso_i;
      if (step_we_i) step_q <= step_i;
    end
  end

  wag_run_bank #(.NUM_VOICES(NUM_VOICES), .VOICE_SEL(VOICE_SEL)) u_run (
    .clk_i, .rst_ni,
    .start_we_i, .stop_we_i,
    .mask_i   (cmd_mask_i),
    .run_o    (run_o),
    .launch_o (launch)
  );

  wag_phase_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_acc (
    .clk_i, .rst_ni,
    .launch_i (launch),
    .run_i    (run_o[VOICE_SEL]),
    .tick_i,
    .step_i   (step_q),
    .eso_i    (eso_q),
    .phase_o  (phase),
    .wrap_o   (wrap_evt)
  );

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_q <= 1'b0;
    else if (wrap_evt) irq_q <= 1'b1;
    else if (irq_clr_we_i && cmd_mask_i[VOICE_SEL]) irq_q <= 1'b0;
  end

  wag_addr_map #(.ADDR_W(ADDR_W), .INT_W(INT_W)) u_map (
    .base_i    (base_q),
    .pos_i     (phase[PW-1:FRAC_W]),
    .eso_i     (eso_q),
    .width16_i,
    .stereo_i,
    .addr_o,
    .half_o
  );

  assign eol_irq_o = irq_q;
endmodule

// File: rtl/wave_addr_gen_chk.sv
module wave_addr_gen_chk #(
  parameter int NUM_VOICES = 4,
  parameter int VOICE_SEL  = 0,
  parameter int PW         = 28
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  start_we_i,
  input logic                  stop_we_i,
  input logic                  irq_clr_we_i,
  input logic [NUM_VOICES-1:0] cmd_mask_i,
  input logic [NUM_VOICES-1:0] run_o,
  input logic [PW-1:0]         phase,
  input logic                  wrap_evt,
  input logic                  eol_irq_o
);
  // R3
  stop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_we_i && cmd_mask_i[VOICE_SEL]) |=> !run_o[VOICE_SEL]);

  // R2
  start_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_we_i && cmd_mask_i[VOICE_SEL] && !(stop_we_i && cmd_mask_i[VOICE_SEL]))
    |=> run_o[VOICE_SEL]);

  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o[VOICE_SEL] && !start_we_i) |=> $stable(phase));

  // R5
  wrap_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_evt |=> eol_irq_o);

  // R6
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_we_i && cmd_mask_i[VOICE_SEL] && !wrap_evt) |=> !eol_irq_o);
endmodule

bind wave_addr_gen wave_addr_gen_chk #(
  .NUM_VOICES(NUM_VOICES), .VOICE_SEL(VOICE_SEL), .PW(INT_W + FRAC_W)
) u_chk (
  .clk_i, .rst_ni, .start_we_i, .stop_we_i, .irq_clr_we_i, .cmd_mask_i,
  .run_o, .phase, .wrap_evt, .eol_irq_o
);

// File: tb/wave_addr_gen_tb.sv
module wave_addr_gen_tb;
  localparam int NV = 4;
  localparam int AW = 24;
  localparam int IW = 16;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_we = 0, stop_we = 0, clr_we = 0;
  logic [NV-1:0] mask = '0;
  logic          base_we = 0, eso_we = 0, step_we = 0;
  logic [AW-1:0] base = '0;
  logic [IW-1:0] eso = '0;
  logic [SW-1:0] step = '0;
  logic          w16 = 0, st = 0, tick = 0;
  logic [NV-1:0] run;
  logic [AW-1:0] addr;
  logic          half, irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  wave_addr_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .start_we_i(start_we), .stop_we_i(stop_we), .irq_clr_we_i(clr_we),
    .cmd_mask_i(mask),
    .base_we_i(base_we), .base_i(base),
    .eso_we_i(eso_we), .eso_i(eso),
    .step_we_i(step_we), .step_i(step),
    .width16_i(w16), .stereo_i(st), .tick_i(tick),
    .run_o(run), .addr_o(addr), .half_o(half), .eol_irq_o(irq)
  );

  task automatic finish_sim();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one-cycle pulse: drive at negedge, release at next negedge
  task automatic cyc();
    @(negedge clk);
    start_we = 0; stop_we = 0; clr_we = 0;
    base_we = 0; eso_we = 0; step_we = 0; tick = 0;
  endtask

  task automatic cfg(input logic [AW-1:0] b, input logic [IW-1:0] e, input logic [SW-1:0] s);
    base = b; eso = e; step = s;
    base_we = 1; eso_we = 1; step_we = 1;
    cyc();
  endtask

  task automatic cmd_start(input logic [NV-1:0] m);
    mask = m; start_we = 1; cyc();
  endtask

  task automatic cmd_stop(input logic [NV-1:0] m);
    mask = m; stop_we = 1; cyc();
  endtask

  task automatic cmd_clr(input logic [NV-1:0] m);
    mask = m; clr_we = 1; cyc();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; cyc();
    end
  endtask

  task automatic t_reset();
    chk("R1 run", run, 0);
    chk("R1 addr", addr, 0);
    chk("R1 half", half, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_run_and_half();
    cfg(24'h1000, 16'd15, 16'h1000);
    cmd_start(4'b0001);
    chk("R2 run set", run, 4'b0001);
    chk("R2 phase zero", addr, 24'h1000);
    ticks(5);
    chk("R4 advance", addr, 24'h1005);
    chk("R7 lower half", half, 0);
    ticks(3);
    chk("R7 upper half", half, 1);
    chk("R8 addr mono8", addr, 24'h1008);
  endtask

  task automatic t_wrap_and_clear();
    ticks(7);
    chk("R5 at end", addr, 24'h100F);
    chk("R5 no irq yet", irq, 0);
    ticks(1);
    chk("R5 folded", addr, 24'h1000);
    chk("R5 irq set", irq, 1);
    cmd_clr(4'b0010);
    chk("R6 other bit keeps irq", irq, 1);
    cmd_clr(4'b0001);
    chk("R6 irq cleared", irq, 0);
  endtask

  task automatic t_start_stop_masks();
    ticks(3);
    cmd_start(4'b0011);
    chk("R2 other voice set", run, 4'b0011);
    chk("R2 running phase kept", addr, 24'h1003);
    cmd_stop(4'b0000);
    chk("R3 zero mask no effect", run, 4'b0011);
    cmd_stop(4'b0001);
    chk("R3 stop bit0", run, 4'b0010);
    ticks(4);
    chk("R4 ticks ignored stopped", addr, 24'h1003);
  endtask

  task automatic t_format();
    w16 = 1; st = 1; #1;
    chk("R8 4-byte frame", addr, 24'h100C);
    w16 = 1; st = 0; #1;
    chk("R8 2-byte frame", addr, 24'h1006);
    w16 = 0; st = 1; #1;
    chk("R8 2-byte stereo8", addr, 24'h1006);
    w16 = 0; st = 0; #1;
  endtask

  task automatic t_frac_wrap();
    cfg(24'h1000, 16'd3, 16'h1800);
    cmd_start(4'b0001);
    chk("R2 relaunch clears phase", addr, 24'h1000);
    ticks(1);
    chk("R4 1.5", addr, 24'h1001);
    ticks(1);
    chk("R4 3.0", addr, 24'h1003);
    chk("R7 half eso3", half, 1);
    ticks(1);
    chk("R5 fold keeps fraction", addr, 24'h1000);
    chk("R5 irq", irq, 1);
    ticks(1);
    chk("R5 fraction carried", addr, 24'h1002);
    cmd_clr(4'b0001);
  endtask

  task automatic t_collide();
    ticks(1);  // phase 3.5
    chk("R6 pre irq clear", irq, 0);
    mask = 4'b0001; tick = 1; clr_we = 1; cyc();  // 5.0 wraps to 1.0
    chk("R6 set beats clear", irq, 1);
    chk("R5 wrap during clear", addr, 24'h1001);
    cmd_clr(4'b0001);
    chk("R6 later clear", irq, 0);
    mask = 4'b0001; start_we = 1; stop_we = 1; cyc();
    chk("R3 stop beats start", run[0], 0);
    ticks(2);
    chk("R3 stopped holds", addr, 24'h1001);
  endtask

  task automatic t_slow_step();
    cfg(24'h2000, 16'd15, 16'h0800);
    cmd_start(4'b0001);
    ticks(1);
    chk("R4 half step", addr, 24'h2000);
    ticks(1);
    chk("R4 two half steps", addr, 24'h2001);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_run_and_half();
    t_wrap_and_clear();
    t_start_stop_masks();
    t_format();
    t_frac_wrap();
    t_collide();
    t_slow_step();
    finish_sim();
  end
endmodule